// File: doc/BRIEF.md
# ROM Read Activity Energy Accumulator

This block sits next to an on-chip ROM and keeps a running estimate of the charge the ROM draws. It watches four things: the read strobe, the word returned by the read, a companion word that the array senses internally as a side effect of the same access, and the output-enable line. Whenever the ROM is activated, and whenever output enable toggles, the block turns the data involved into population counts and bit-transition counts. It weights those counts with programmable signed coefficients and adds the weighted sum to a saturating signed total.

Each activation is priced as a linear function of six quantities: the weight of the new word, the weight of the word previously on the internal read bus, the weight of the side-effect word, the number of bus bits that rise, the number that fall, and a constant. One of two coefficient banks is used, chosen by the enable level. Each enable edge is priced from four quantities: the weight of the word now presented, the rising and falling bit counts against the word last visible at the output, and a constant. The bank here is chosen by the direction of the edge. The block also supplies the companion address, which is the requested address XORed with a fixed mask, so the system can fetch the side-effect word.

Top module: `rom_energy_acc`

## Requirements
- R1: After reset the total reads 0, every coefficient is 0, the internal bus word and the last-output word are 0, and the remembered enable level is low.
- R2: A write with `cfg_we` high stores `cfg_wdata` into coefficient slot `cfg_addr`. Slots 0..5 are the low-enable activation bank (weight of new word, weight of previous bus word, weight of side word, rising count, falling count, constant). Slots 6..11 are the high-enable activation bank in the same order. Slots 12..15 are the rising-edge output bank (weight of presented word, rising count, falling count, constant). Slots 16..19 are the falling-edge bank in the same order. Writes to slots 20 and above change nothing.
- R3: A cycle with `rd_stb` high adds the activation sum, computed on the new word `rd_word`, the previous bus word, and `side_word`, with R and F counted from the previous bus word to the new one.
- R4: The activation bank is the high-enable bank when the enable level sampled on the previous cycle was high, and the low-enable bank otherwise.
- R5: After a read, the bus word used by the next activation is that read's `rd_word`.
- R6: A cycle where `oe` differs from its previous-cycle level adds the output sum, using the rising bank on a 0-to-1 change and the falling bank on a 1-to-0 change. The presented word is `rd_word` if a read occurs in that cycle and the bus word otherwise; R and F are counted from the last-output word to it.
- R7: On a rising enable edge the last-output word takes the presented word. A falling edge leaves it unchanged.
- R8: A read and an enable edge in the same cycle add both sums in that cycle, and the activation uses the pre-edge enable level.
- R9: The total is a two's complement value of `AW` bits. It clamps at the largest positive and the most negative value instead of wrapping.
- R10: `side_addr` equals `rd_addr` XOR `SIDE_MASK`, combinationally.
- R11: The total changes only on the clock edge that samples an event, so it is visible one cycle after the inputs are presented. Cycles with no read and no enable change leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 5 | Coefficient slot |
| cfg_wdata | input | CW | Signed coefficient value |
| rd_stb | input | 1 | ROM activation strobe |
| rd_addr | input | RAW | Requested ROM address |
| rd_word | input | DW | Word returned by the read |
| side_word | input | DW | Word sensed at the companion address |
| oe | input | 1 | ROM output enable level |
| side_addr | output | RAW | Companion address (rd_addr XOR SIDE_MASK) |
| energy_total | output | AW | Signed saturating energy total |

## Verification
The bench builds the block with DW=4, CW=16, AW=24, RAW=6 and SIDE_MASK=6'h21. With 4-bit words, every pair of previous and new bus word can be visited under both activation banks, and the 64-entry companion-address map can be swept completely. The 24-bit total keeps the full-scale coefficients able to reach both saturation rails in a few dozen reads. This makes the clamp behaviour in each direction, and the recovery from it, directly observable.

// File: rtl/rom_energy_pkg.sv
package rom_energy_pkg;

   // coefficient file layout (slot indices)
   localparam int unsigned ACT_TERMS     = 6;
   localparam int unsigned OUT_TERMS     = 4;
   localparam int unsigned ACT_LO_BASE   = 0;
   localparam int unsigned ACT_HI_BASE   = 6;
   localparam int unsigned OUT_RISE_BASE = 12;
   localparam int unsigned OUT_FALL_BASE = 16;
   localparam int unsigned NUM_COEF      = 20;
   localparam int unsigned COEF_AW       = 5;

   typedef enum logic [1:0] {
      EN_STEADY = 2'd0,
      EN_RISE   = 2'd1,
      EN_FALL   = 2'd2
   } en_change_e;

endpackage

// File: rtl/rom_energy_popcnt.sv
module rom_energy_popcnt #(
   parameter int unsigned DW   = 8,
   parameter int unsigned CNTW = $clog2(DW + 1)
) (
   input  logic [DW-1:0]   vec,
   output logic [CNTW-1:0] cnt
);

   if (CNTW < $clog2(DW + 1)) begin : g_chk_cntw
      $error("rom_energy_popcnt: CNTW too narrow for DW");
   end

   if (DW == 1) begin : g_single
      assign cnt = CNTW'(vec[0]);
   end else begin : g_multi
      always_comb begin
         cnt = '0;
         for (int i = 0; i < DW; i++) begin
            cnt = cnt + CNTW'(vec[i]);
         end
      end
   end

endmodule

// File: rtl/rom_energy_edges.sv
module rom_energy_edges #(
   parameter int unsigned DW   = 8,
   parameter int unsigned CNTW = $clog2(DW + 1)
) (
   input  logic [DW-1:0]   prev_w,
   input  logic [DW-1:0]   next_w,
   output logic [CNTW-1:0] up_cnt,
   output logic [CNTW-1:0] dn_cnt
);

   logic [DW-1:0] up_v;
   logic [DW-1:0] dn_v;

   for (genvar b = 0; b < DW; b++) begin : g_bit
      assign up_v[b] = ~prev_w[b] &  next_w[b];
      assign dn_v[b] =  prev_w[b] & ~next_w[b];
   end

   rom_energy_popcnt #(.DW(DW), .CNTW(CNTW)) u_up (.vec(up_v), .cnt(up_cnt));
   rom_energy_popcnt #(.DW(DW), .CNTW(CNTW)) u_dn (.vec(dn_v), .cnt(dn_cnt));

endmodule

// File: rtl/rom_energy_lincomb.sv
module rom_energy_lincomb #(
   parameter int unsigned CW   = 16,
   parameter int unsigned CNTW = 4,
   parameter int unsigned NT   = 6,
   parameter int unsigned OW   = 24
) (
   input  logic [NT*CW-1:0]   coef_flat,
   input  logic [NT*CNTW-1:0] cnt_flat,
   output logic signed [OW-1:0] sum
);

   localparam int unsigned PW = CW + CNTW + 1;

   if (OW < PW + $clog2(NT)) begin : g_chk_ow
      $error("rom_energy_lincomb: OW cannot hold the sum of NT products");
   end

   logic signed [PW-1:0] prod [NT];

   for (genvar g = 0; g < NT; g++) begin : g_term
      logic signed [CW-1:0] c_s;
      logic signed [CNTW:0] n_s;
      assign c_s     = $signed(coef_flat[g*CW +: CW]);
      assign n_s     = $signed({1'b0, cnt_flat[g*CNTW +: CNTW]});
      assign prod[g] = PW'(c_s) * PW'(n_s);
   end

   always_comb begin
      sum = '0;
      for (int i = 0; i < NT; i++) begin
         sum = sum + OW'(prod[i]);
      end
   end

endmodule

// File: rtl/rom_energy_coef_bank.sv
module rom_energy_coef_bank #(
   parameter int unsigned CW    = 16,
   parameter int unsigned NCOEF = 20,
   parameter int unsigned CAW   = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [CAW-1:0]      addr,
   input  logic [CW-1:0]       wdata,
   output logic [NCOEF*CW-1:0] coef_flat
);

   if (NCOEF >= (1 << CAW)) begin : g_chk_caw
      $error("rom_energy_coef_bank: CAW must leave unused slot codes");
   end

   for (genvar g = 0; g < NCOEF; g++) begin : g_slot
      logic [CW-1:0] r_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            r_q <= '0;
         end else if (we && (addr == CAW'(g))) begin
            r_q <= wdata;
         end
      end
      assign coef_flat[g*CW +: CW] = r_q;
   end

   // R2: an in-range write lands in its slot
   a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (addr < CAW'(NCOEF))) |=> (coef_flat[$past(addr)*CW +: CW] == $past(wdata)));

   // R2: out-of-range writes change nothing
   a_r2_outside_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (addr >= CAW'(NCOEF))) |=> $stable(coef_flat));

endmodule

// File: rtl/rom_energy_satacc.sv
module rom_energy_satacc #(
   parameter int unsigned AW  = 48,
   parameter int unsigned DLW = 24
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic signed [DLW-1:0] delta,
   output logic signed [AW-1:0]  acc
);

   localparam int unsigned SW = ((AW > DLW) ? AW : DLW) + 1;

   logic signed [SW-1:0] wide;
   logic                 ovf;
   logic [AW-1:0]        nxt;

   always_comb begin
      wide = SW'(acc) + SW'(delta);
      ovf  = (wide[SW-1:AW-1] != {(SW-AW+1){wide[SW-1]}});
      if (!ovf) begin
         nxt = wide[AW-1:0];
      end else if (wide[SW-1]) begin
         nxt = {1'b1, {(AW-1){1'b0}}};
      end else begin
         nxt = {1'b0, {(AW-1){1'b1}}};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc <= '0;
      end else begin
         acc <= $signed(nxt);
      end
   end

   // R9: a non-negative contribution never lowers the total
   a_r9_no_drop_on_gain: assert property (@(posedge clk) disable iff (!rst_n)
      (delta >= 0) |=> (acc >= $past(acc)));

   // R9: a non-positive contribution never raises the total
   a_r9_no_rise_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
      (delta <= 0) |=> (acc <= $past(acc)));

endmodule

// File: rtl/rom_energy_acc.sv
module rom_energy_acc #(
   parameter int unsigned     DW        = 16,
   parameter int unsigned     CW        = 16,
   parameter int unsigned     AW        = 48,
   parameter int unsigned     RAW       = 10,
   parameter logic [RAW-1:0]  SIDE_MASK = RAW'(1)
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               cfg_we,
   input  logic [rom_energy_pkg::COEF_AW-1:0] cfg_addr,
   input  logic [CW-1:0]                      cfg_wdata,
   input  logic                               rd_stb,
   input  logic [RAW-1:0]                     rd_addr,
   input  logic [DW-1:0]                      rd_word,
   input  logic [DW-1:0]                      side_word,
   input  logic                               oe,
   output logic [RAW-1:0]                     side_addr,
   output logic [AW-1:0]                      energy_total
);

   import rom_energy_pkg::*;

   localparam int unsigned CNTW = $clog2(DW + 1);
   localparam int unsigned SOW  = CW + CNTW + 1 + 3;
   localparam int unsigned DLW  = SOW + 1;

   if (DW < 1 || DW > 64) begin : g_chk_dw
      $error("rom_energy_acc: DW out of range");
   end
   if (CW < 2) begin : g_chk_cw
      $error("rom_energy_acc: CW too small");
   end
   if (AW < 8) begin : g_chk_aw
      $error("rom_energy_acc: AW too small");
   end

   // ---------------- state ----------------
   logic          oe_q;
   logic [DW-1:0] bus_q;
   logic [DW-1:0] vis_q;
   en_change_e    en_chg;
   logic [DW-1:0] shown_w;

   always_comb begin
      if (oe && !oe_q) begin
         en_chg = EN_RISE;
      end else if (!oe && oe_q) begin
         en_chg = EN_FALL;
      end else begin
         en_chg = EN_STEADY;
      end
   end

   assign shown_w = rd_stb ? rd_word : bus_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oe_q  <= 1'b0;
         bus_q <= '0;
         vis_q <= '0;
      end else begin
         oe_q <= oe;
         if (rd_stb) begin
            bus_q <= rd_word;
         end
         if (en_chg == EN_RISE) begin
            vis_q <= shown_w;
         end
      end
   end

   assign side_addr = rd_addr ^ SIDE_MASK;

   // ---------------- coefficients ----------------
   logic [NUM_COEF*CW-1:0] coef_flat;

   rom_energy_coef_bank #(.CW(CW), .NCOEF(NUM_COEF), .CAW(COEF_AW)) u_coef (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cfg_we),
      .addr      (cfg_addr),
      .wdata     (cfg_wdata),
      .coef_flat (coef_flat)
   );

   // ---------------- bit statistics ----------------
   logic [CNTW-1:0] n_new, n_bus, n_side, n_shown;
   logic [CNTW-1:0] bus_up, bus_dn, out_up, out_dn;
   logic [CNTW-1:0] one_c;

   assign one_c = CNTW'(1);

   rom_energy_popcnt #(.DW(DW), .CNTW(CNTW)) u_pc_new   (.vec(rd_word),   .cnt(n_new));
   rom_energy_popcnt #(.DW(DW), .CNTW(CNTW)) u_pc_bus   (.vec(bus_q),     .cnt(n_bus));
   rom_energy_popcnt #(.DW(DW), .CNTW(CNTW)) u_pc_side  (.vec(side_word), .cnt(n_side));
   rom_energy_popcnt #(.DW(DW), .CNTW(CNTW)) u_pc_shown (.vec(shown_w),   .cnt(n_shown));

   rom_energy_edges #(.DW(DW), .CNTW(CNTW)) u_ed_bus (
      .prev_w (bus_q), .next_w (rd_word), .up_cnt (bus_up), .dn_cnt (bus_dn));
   rom_energy_edges #(.DW(DW), .CNTW(CNTW)) u_ed_out (
      .prev_w (vis_q), .next_w (shown_w), .up_cnt (out_up), .dn_cnt (out_dn));

   // ---------------- activation term ----------------
   logic [ACT_TERMS*CW-1:0]   act_coef;
   logic [ACT_TERMS*CNTW-1:0] act_cnt;
   logic signed [SOW-1:0]     act_sum;

   assign act_coef = oe_q ? coef_flat[ACT_HI_BASE*CW +: ACT_TERMS*CW]
                          : coef_flat[ACT_LO_BASE*CW +: ACT_TERMS*CW];
   assign act_cnt  = {one_c, bus_dn, bus_up, n_side, n_bus, n_new};

   rom_energy_lincomb #(.CW(CW), .CNTW(CNTW), .NT(ACT_TERMS), .OW(SOW)) u_act (
      .coef_flat (act_coef),
      .cnt_flat  (act_cnt),
      .sum       (act_sum)
   );

   // ---------------- output-enable term ----------------
   logic [OUT_TERMS*CW-1:0]   out_coef;
   logic [OUT_TERMS*CNTW-1:0] out_cnt;
   logic signed [SOW-1:0]     out_sum;

   assign out_coef = (en_chg == EN_RISE) ? coef_flat[OUT_RISE_BASE*CW +: OUT_TERMS*CW]
                                         : coef_flat[OUT_FALL_BASE*CW +: OUT_TERMS*CW];
   assign out_cnt  = {one_c, out_dn, out_up, n_shown};

   rom_energy_lincomb #(.CW(CW), .CNTW(CNTW), .NT(OUT_TERMS), .OW(SOW)) u_out (
      .coef_flat (out_coef),
      .cnt_flat  (out_cnt),
      .sum       (out_sum)
   );

   // ---------------- accumulation ----------------
   logic signed [DLW-1:0] act_ext, out_ext, delta;
   logic signed [AW-1:0]  acc;

   assign act_ext = rd_stb ? DLW'(act_sum) : '0;
   assign out_ext = (en_chg != EN_STEADY) ? DLW'(out_sum) : '0;
   assign delta   = act_ext + out_ext;

   rom_energy_satacc #(.AW(AW), .DLW(DLW)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .delta (delta),
      .acc   (acc)
   );

   assign energy_total = acc;

   // R11: quiet cycles leave the total untouched
   a_r11_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_stb && (oe == oe_q)) |=> $stable(energy_total));

   // R7: a falling enable edge keeps the last-output word
   a_r7_fall_keeps_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_q && !oe) |=> $stable(vis_q));

endmodule

// File: tb/rom_energy_acc_tb.sv
module rom_energy_acc_tb;

   localparam int unsigned DW  = 4;
   localparam int unsigned CW  = 16;
   localparam int unsigned AW  = 24;
   localparam int unsigned RAW = 6;
   localparam logic [RAW-1:0] MASK = 6'h21;
   localparam longint MAXV = (longint'(1) <<< (AW-1)) - 1;
   localparam longint MINV = -(longint'(1) <<< (AW-1));

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [4:0] cfg_addr = '0;
   logic [CW-1:0] cfg_wdata = '0;
   logic rd_stb = 1'b0;
   logic [RAW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_word = '0;
   logic [DW-1:0] side_word = '0;
   logic oe = 1'b0;
   logic [RAW-1:0] side_addr;
   logic [AW-1:0] energy_total;

   always #10 clk = ~clk;

   rom_energy_acc #(.DW(DW), .CW(CW), .AW(AW), .RAW(RAW), .SIDE_MASK(MASK)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .rd_stb(rd_stb), .rd_addr(rd_addr),
      .rd_word(rd_word), .side_word(side_word), .oe(oe),
      .side_addr(side_addr), .energy_total(energy_total));

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   longint tot_m = 0;
   logic [DW-1:0] bus_m = '0;
   logic [DW-1:0] vis_m = '0;
   bit oeq_m = 1'b0;
   longint coef_m [20];

   function automatic longint pc(logic [DW-1:0] v);
      longint n = 0;
      for (int i = 0; i < DW; i++) n += longint'(v[i]);
      return n;
   endfunction

   function automatic longint total_now();
      return longint'($signed(energy_total));
   endfunction

   task automatic chk(string req, longint got, longint exp);
      nchk++;
      if (got != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
      end
   endtask

   task automatic wr_coef(int a, longint v);
      cfg_we = 1'b1;
      cfg_addr = 5'(a);
      cfg_wdata = CW'(v);
      rd_stb = 1'b0;
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0;
      if (a < 20) coef_m[a] = v;
   endtask

   // drive one cycle of activity, predict, check after the edge
   task automatic cyc(bit rd, logic [DW-1:0] w, logic [DW-1:0] sw, bit o, string req);
      longint d = 0;
      int b;
      logic [DW-1:0] shown;
      rd_stb = rd;
      rd_word = w;
      side_word = sw;
      oe = o;
      #1;
      chk("R11 latency", total_now(), tot_m);
      shown = rd ? w : bus_m;
      if (rd) begin
         b = oeq_m ? 6 : 0;
         d += coef_m[b]   * pc(w)
            + coef_m[b+1] * pc(bus_m)
            + coef_m[b+2] * pc(sw)
            + coef_m[b+3] * pc(~bus_m & w)
            + coef_m[b+4] * pc(bus_m & ~w)
            + coef_m[b+5];
      end
      if (o != oeq_m) begin
         b = o ? 12 : 16;
         d += coef_m[b]   * pc(shown)
            + coef_m[b+1] * pc(~vis_m & shown)
            + coef_m[b+2] * pc(vis_m & ~shown)
            + coef_m[b+3];
         if (o) vis_m = shown;
      end
      if (rd) bus_m = w;
      oeq_m = o;
      tot_m = tot_m + d;
      if (tot_m > MAXV) tot_m = MAXV;
      if (tot_m < MINV) tot_m = MINV;
      @(posedge clk);
      @(negedge clk);
      chk(req, total_now(), tot_m);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nfail++;
         nchk++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 20; i++) coef_m[i] = 0;
      repeat (3) @(negedge clk);
      chk("R1 total in reset", total_now(), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 total after reset", total_now(), 0);

      // R1: zero coefficients give zero cost for reads and enable edges
      cyc(1, 4'hF, 4'hF, 0, "R1 zero coef read");
      cyc(0, 4'h0, 4'h0, 1, "R1 zero coef rise");
      cyc(0, 4'h0, 4'h0, 0, "R1 zero coef fall");

      // R10: full companion address sweep
      for (int a = 0; a < 64; a++) begin
         rd_addr = 6'(a);
         #1;
         chk("R10 side_addr", longint'(side_addr), longint'(6'(a) ^ MASK));
      end

      // R2: program all banks with distinct signed values
      begin
         longint vals [20] = '{3, -5, 7, 11, -13, 17,
                               101, 19, -23, 29, 31, -37,
                               41, 43, -47, 53,
                               -59, 61, 67, -71};
         for (int i = 0; i < 20; i++) wr_coef(i, vals[i]);
      end
      // R2: out-of-range slots are ignored (later predictions exclude them)
      wr_coef(20, 16'sh7FFF);
      wr_coef(31, -1000);
      chk("R2 ignored write no cost", total_now(), tot_m);

      // R3, R5: every previous/new pair under the low bank
      for (int p = 0; p < 16; p++) begin
         for (int s = 0; s < 16; s++) begin
            cyc(1, 4'(p), 4'(s ^ 5), 0, "R3 R5 low bank prev");
            cyc(1, 4'(s), 4'(p + s), 0, "R3 R5 low bank pair");
         end
      end

      // R6, R7: enable edges alone, various bus words
      for (int s = 0; s < 16; s++) begin
         cyc(1, 4'(s), 4'h0, 0, "R5 load bus");
         cyc(0, 4'h0, 4'h0, 1, "R6 R7 rise alone");
         cyc(0, 4'h0, 4'h0, 1, "R11 hold high");
         cyc(0, 4'h0, 4'h0, 0, "R6 fall alone");
         cyc(0, 4'h0, 4'h0, 0, "R11 hold low");
      end

      // R4: high bank sweep
      cyc(0, 4'h0, 4'h0, 1, "R6 rise before high bank");
      for (int p = 0; p < 16; p++) begin
         for (int s = 0; s < 16; s++) begin
            cyc(1, 4'(p), 4'(s), 1, "R4 high bank prev");
            cyc(1, 4'(s), 4'(15 - p), 1, "R4 high bank pair");
         end
      end

      // R8: read together with an enable edge
      for (int s = 0; s < 16; s++) begin
         cyc(1, 4'(s), 4'(s), 0, "R8 read with fall");
         cyc(1, 4'(15 - s), 4'(s), 1, "R8 read with rise");
         cyc(0, 4'h0, 4'h0, 1, "R11 idle after rise");
         cyc(1, 4'(s ^ 9), 4'h3, 1, "R7 visible word used");
      end
      cyc(0, 4'h0, 4'h0, 0, "R6 final fall");

      // R9: drive to the positive rail
      for (int i = 0; i < 6; i++) wr_coef(i, 32767);
      for (int i = 0; i < 30; i++) cyc(1, 4'hF, 4'hF, 0, "R9 clamp high");
      chk("R9 at max", total_now(), MAXV);
      // R9: drive to the negative rail
      for (int i = 0; i < 6; i++) wr_coef(i, -32768);
      for (int i = 0; i < 50; i++) cyc(1, 4'hF, 4'hF, 0, "R9 clamp low");
      chk("R9 at min", total_now(), MINV);
      // recovery from the negative rail
      wr_coef(5, 1000);
      for (int i = 0; i < 5; i++) wr_coef(i, 0);
      cyc(1, 4'hA, 4'h0, 0, "R9 recover");

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule